// File: doc/BRIEF.md
# Parallel Port Service Interrupt Generator

This block turns the interrupt conditions of an extended-capability parallel port with a 16-byte FIFO into pulses on a shareable interrupt line. It takes the port's control bits (service-interrupt disable, DMA enable, transfer direction, active-low error-interrupt enable and acknowledge-interrupt enable) as levels. It also takes the FIFO occupancy, a 4-bit threshold field, a terminal-count strobe from the DMA engine, and the raw peripheral fault and acknowledge pins. Every interrupt event makes the block drive the line low for a fixed number of clocks. After that the driver goes to high impedance so that other sources can share the same wire. The line is shown here as an output enable plus a data value.

In programmed I/O the host is called when enough room has opened up in the FIFO (host-to-peripheral) or when enough bytes have arrived (peripheral-to-host). In DMA mode the block calls the host on terminal count and asks the register file to set the service-disable bit, which stops DMA. The block also raises a fault interrupt and an acknowledge interrupt, and it has no other function.

Top module: `ppsi_irq_top`

## Requirements
- R1: During and right after reset the line is released (`irq_oe_o`=0) and `svc_set_o` is 0.
- R2: The effective threshold is the 4-bit field plus one (1..16). With direction 1 (peripheral to host), the programmed-I/O condition holds when the occupancy is at least the effective threshold.
- R3: With direction 0 (host to peripheral), the programmed-I/O condition holds when 16 minus the occupancy is at least the effective threshold.
- R4: A programmed-I/O condition that stays true gives one pulse only, when it becomes true. It fires again only after it has gone false and come true again.
- R5: While `svc_off_i`=1, neither programmed-I/O nor terminal-count events occur. Clearing `svc_off_i` from 1 to 0 while the condition already holds gives a pulse, with the line driven on the next clock.
- R6: With `dma_en_i`=1, programmed-I/O conditions give no pulse. A `tc_i` strobe with `dma_en_i`=1 and `svc_off_i`=0 gives a pulse and raises `svc_set_o` in the same cycle as the strobe.
- R7: With `err_en_n_i`=0, a high-to-low edge on `fault_n_i` gives a pulse, with the line driven three clocks after the pin changes. With `err_en_n_i`=1 the same edge gives none, and a low-to-high fault edge never gives one.
- R8: A change of `err_en_n_i` from 1 to 0 while the synchronized fault is low gives a pulse.
- R9: With `ack_en_i`=1, a low-to-high edge on `ack_n_i` gives a pulse. A falling edge, or any edge while `ack_en_i`=0, gives none.
- R10: Each pulse drives the line for exactly PULSE_W (default 4) clocks, and the data value is 0 whenever the line is driven.
- R11: An event that arrives during a pulse restarts it, so the line stays driven for PULSE_W clocks after the latest event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| svc_off_i | input | 1 | Service-interrupt disable bit |
| dma_en_i | input | 1 | DMA enable bit |
| dir_i | input | 1 | Direction: 0 host to peripheral, 1 peripheral to host |
| err_en_n_i | input | 1 | Error-interrupt enable, active low |
| ack_en_i | input | 1 | Acknowledge-interrupt enable |
| fifo_cnt_i | input | 5 | FIFO occupancy, 0..16 |
| thr_fld_i | input | 4 | Programmed threshold field (effective value is field+1) |
| tc_i | input | 1 | DMA terminal-count strobe, one cycle |
| fault_n_i | input | 1 | Raw peripheral fault pin, active low |
| ack_n_i | input | 1 | Raw peripheral acknowledge pin |
| irq_oe_o | output | 1 | Interrupt line driver enable |
| irq_o | output | 1 | Interrupt line value while driven |
| svc_set_o | output | 1 | Request to set the service-disable bit |

## Verification
The hardest case to reach from the ports is a programmed-I/O condition that is already true at the moment the service bit is cleared. The condition has to become true while the block cannot fire, and then fire through the enabling edge alone. The bench sets every pairing of the threshold field and the occupancy, in both directions, while the service bit is 1. It then clears the bit and compares the pulse count with the arithmetic expectation. Ramps of the occupancy upward, downward and back up check that a condition which stays true does not fire again, and two closely spaced terminal-count strobes stretch a pulse.

// File: rtl/ppsi_pkg.sv
package ppsi_pkg;

  // effective threshold from the programmed field
  function automatic int unsigned eff_thr(input int unsigned fld);
    return fld + 1;
  endfunction

  // free entries of a FIFO of the given depth
  function automatic int unsigned free_slots(input int unsigned depth,
                                             input int unsigned cnt);
    return (cnt >= depth) ? 0 : depth - cnt;
  endfunction

  // programmed-I/O service condition for one direction
  function automatic logic pio_met(input logic dir_fill,
                                   input int unsigned depth,
                                   input int unsigned cnt,
                                   input int unsigned fld);
    if (dir_fill) return cnt >= eff_thr(fld);
    return free_slots(depth, cnt) >= eff_thr(fld);
  endfunction

endpackage

// File: rtl/ppsi_sync_edge.sv
module ppsi_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic            prev_q;

  generate
    if (STAGES > 0) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {SH_W{RST_VAL}};
        else        sh_q <= {sh_q[SH_W-2:0], din};
      end
      assign level_o = sh_q[STAGES-1];
      assign prev_q  = sh_q[STAGES];
    end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {SH_W{RST_VAL}};
        else        sh_q <= {SH_W{din}};
      end
      assign level_o = din;
      assign prev_q  = sh_q[0];
    end
  endgenerate

  assign rise_o = level_o & ~prev_q;
  assign fall_o = ~level_o & prev_q;
endmodule

// File: rtl/ppsi_level_cond.sv
module ppsi_level_cond
  import ppsi_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_off_i,
  input  logic             dma_en_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             met_o,
  output logic             evt_o
);
  logic gated;
  logic gated_q;

  assign met_o = pio_met(dir_i, DEPTH, 32'(cnt_i), 32'(thr_i));
  assign gated = met_o & ~svc_off_i & ~dma_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gated_q <= 1'b0;
    else        gated_q <= gated;
  end

  assign evt_o = gated & ~gated_q;
endmodule

// File: rtl/ppsi_pulse_drv.sv
module ppsi_pulse_drv #(
  parameter int PULSE_W = 4,
  parameter int PC_W    = $clog2(PULSE_W + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic oe_o,
  output logic val_o
);
  logic [PC_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (trig_i)         left_q <= PC_W'(PULSE_W);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign oe_o  = (left_q != '0);
  assign val_o = ~oe_o;
endmodule

// File: rtl/ppsi_irq_top.sv
module ppsi_irq_top #(
  parameter int DEPTH       = 16,
  parameter int PULSE_W     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(DEPTH + 1),
  parameter int THR_W       = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_off_i,
  input  logic             dma_en_i,
  input  logic             dir_i,
  input  logic             err_en_n_i,
  input  logic             ack_en_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic [THR_W-1:0] thr_fld_i,
  input  logic             tc_i,
  input  logic             fault_n_i,
  input  logic             ack_n_i,
  output logic             irq_oe_o,
  output logic             irq_o,
  output logic             svc_set_o
);
  // named event wires, observed by the checker
  logic lvl_met, lvl_evt;
  logic tc_evt, err_evt, ack_evt, any_evt;
  logic fault_lvl, fault_rise, fault_fall;
  logic ack_lvl, ack_rise, ack_fall;
  logic err_en_n_q;

  ppsi_level_cond #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) lvl_i (
    .clk(clk), .rst_n(rst_n), .svc_off_i(svc_off_i), .dma_en_i(dma_en_i),
    .dir_i(dir_i), .cnt_i(fifo_cnt_i), .thr_i(thr_fld_i),
    .met_o(lvl_met), .evt_o(lvl_evt)
  );

  ppsi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) flt_i (
    .clk(clk), .rst_n(rst_n), .din(fault_n_i),
    .level_o(fault_lvl), .rise_o(fault_rise), .fall_o(fault_fall)
  );

  ppsi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) ack_sync_i (
    .clk(clk), .rst_n(rst_n), .din(ack_n_i),
    .level_o(ack_lvl), .rise_o(ack_rise), .fall_o(ack_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_en_n_q <= 1'b1;
    else        err_en_n_q <= err_en_n_i;
  end

  assign tc_evt  = tc_i & dma_en_i & ~svc_off_i;
  assign err_evt = (~err_en_n_i & fault_fall)
                 | (err_en_n_q & ~err_en_n_i & ~fault_lvl);
  assign ack_evt = ack_en_i & ack_rise;
  assign any_evt = lvl_evt | tc_evt | err_evt | ack_evt;

  assign svc_set_o = tc_evt;

  ppsi_pulse_drv #(.PULSE_W(PULSE_W)) drv_i (
    .clk(clk), .rst_n(rst_n), .trig_i(any_evt),
    .oe_o(irq_oe_o), .val_o(irq_o)
  );
endmodule

// File: rtl/ppsi_irq_chk.sv
module ppsi_irq_chk #(
  parameter int PULSE_W = 4
) (
  input logic clk,
  input logic rst_n,
  input logic svc_off_i,
  input logic dma_en_i,
  input logic tc_i,
  input logic irq_oe_o,
  input logic irq_o,
  input logic svc_set_o,
  input logic lvl_evt,
  input logic any_evt
);
  int unsigned since_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= 0;
      seen_q  <= 1'b0;
    end else if (any_evt) begin
      since_q <= 0;
      seen_q  <= 1'b1;
    end else if (since_q < PULSE_W + 1) begin
      since_q <= since_q + 1;
    end
  end

  a_r10_low_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe_o |-> !irq_o);

  a_r10_event_drives: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> irq_oe_o);

  a_r11_window: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe_o == (seen_q && since_q < PULSE_W));

  a_r4_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_evt |=> !lvl_evt);

  a_r5_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    svc_off_i |-> (!lvl_evt && !svc_set_o));

  a_r6_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
    svc_set_o |-> (tc_i && dma_en_i));

  a_r6_dma_blocks_pio: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en_i |-> !lvl_evt);
endmodule

bind ppsi_irq_top ppsi_irq_chk #(.PULSE_W(PULSE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .svc_off_i(svc_off_i), .dma_en_i(dma_en_i),
  .tc_i(tc_i), .irq_oe_o(irq_oe_o), .irq_o(irq_o), .svc_set_o(svc_set_o),
  .lvl_evt(lvl_evt), .any_evt(any_evt)
);

// File: tb/ppsi_irq_top_tb_top.sv
module ppsi_irq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int PW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic svc_off = 1'b1, dma_en = 1'b0, dir = 1'b0, err_en_n = 1'b1, ack_en = 1'b0;
  logic [4:0] cnt = '0;
  logic [3:0] thr = '0;
  logic tc = 1'b0, fault_n = 1'b1, ack_n = 1'b1;
  logic oe, val, sset;

  int checks = 0, fails = 0;
  int pulses = 0, run = 0, last_w = 0, bad_val = 0;
  logic oe_prev = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppsi_irq_top dut_i (
    .clk(clk), .rst_n(rst_n), .svc_off_i(svc_off), .dma_en_i(dma_en),
    .dir_i(dir), .err_en_n_i(err_en_n), .ack_en_i(ack_en),
    .fifo_cnt_i(cnt), .thr_fld_i(thr), .tc_i(tc),
    .fault_n_i(fault_n), .ack_n_i(ack_n),
    .irq_oe_o(oe), .irq_o(val), .svc_set_o(sset)
  );

  // line monitor: samples a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (oe && !oe_prev) begin pulses++; run = 1; end
    else if (oe) run++;
    if (!oe && oe_prev) last_w = run;
    if (oe && val !== 1'b0) bad_val++;
    oe_prev = oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int exp_met(input logic d, input int c, input int f);
    int room;
    room = DEPTH - c;
    return d ? int'(c >= f + 1) : int'(room >= f + 1);
  endfunction

  initial begin
    int p0;
    tick(3);
    chk(oe, 0, "R1 oe in reset");
    chk(sset, 0, "R1 svc_set in reset");
    rst_n = 1'b1;
    tick(2);
    chk(oe, 0, "R1 oe after reset");
    chk(pulses, 0, "R1 no pulse after reset");

    // R2/R3/R5 sweep: enable edge with condition preset
    for (int d = 0; d < 2; d++) begin
      for (int f = 0; f < 16; f++) begin
        for (int c = 0; c <= DEPTH; c++) begin
          svc_off = 1'b1; dir = d[0]; thr = f[3:0]; cnt = c[4:0];
          tick(2);
          p0 = pulses;
          svc_off = 1'b0;
          tick(PW + 4);
          chk(pulses - p0, exp_met(d[0], c, f), d ? "R2 fill sweep" : "R3 drain sweep");
          svc_off = 1'b1;
          tick(1);
        end
      end
    end

    // R5/R10 latency and width
    svc_off = 1'b1; dir = 1'b1; thr = 4'd0; cnt = 5'd16;
    tick(2);
    chk(oe, 0, "R5 idle before enable");
    svc_off = 1'b0;
    tick(1);
    chk(oe, 1, "R5 driven one clock after clear");
    tick(PW + 2);
    chk(last_w, PW, "R10 pulse width");
    chk(bad_val, 0, "R10 value low while driven");
    svc_off = 1'b1; tick(2);

    // R4 ramp: one pulse while condition stays true
    cnt = 5'd0; dir = 1'b1; thr = 4'd3;
    tick(2);
    p0 = pulses;
    svc_off = 1'b0;
    for (int c = 0; c <= DEPTH; c++) begin cnt = c[4:0]; tick(2); end
    tick(PW + 2);
    chk(pulses - p0, 1, "R4 single pulse on ramp up");
    for (int c = DEPTH; c >= 0; c--) begin cnt = c[4:0]; tick(2); end
    chk(pulses - p0, 1, "R4 no pulse ramping down");
    for (int c = 0; c <= 5; c++) begin cnt = c[4:0]; tick(2); end
    tick(PW + 2);
    chk(pulses - p0, 2, "R4 refire after going false");

    // R5: service off blocks terminal count
    svc_off = 1'b1; dma_en = 1'b1; cnt = 5'd0;
    tick(2);
    p0 = pulses;
    tc = 1'b1; #1;
    chk(sset, 0, "R5 svc_set blocked while off");
    tick(1); tc = 1'b0;
    tick(PW + 2);
    chk(pulses - p0, 0, "R5 tc blocked while off");

    // R6: DMA blocks PIO; tc fires and sets
    dir = 1'b1; cnt = 5'd16; thr = 4'd0;
    tick(1);
    svc_off = 1'b0;
    tick(PW + 2);
    chk(pulses - p0, 0, "R6 dma blocks pio");
    tc = 1'b1; #1;
    chk(sset, 1, "R6 svc_set with tc");
    tick(1); tc = 1'b0; #1;
    chk(sset, 0, "R6 svc_set one cycle");
    tick(PW + 2);
    chk(pulses - p0, 1, "R6 tc pulse");

    // R11: retrigger stretches pulse
    p0 = pulses;
    tc = 1'b1; tick(1); tc = 1'b0; tick(1);
    tc = 1'b1; tick(1); tc = 1'b0;
    tick(PW + 3);
    chk(pulses - p0, 1, "R11 single stretched pulse");
    chk(last_w, PW + 2, "R11 stretched width");
    dma_en = 1'b0; svc_off = 1'b1; cnt = 5'd0;
    tick(2);

    // R7: fault falling edge
    err_en_n = 1'b0; tick(2);
    p0 = pulses;
    fault_n = 1'b0;
    tick(2);
    chk(oe, 0, "R7 not yet driven after two clocks");
    tick(1);
    chk(oe, 1, "R7 driven three clocks after fault");
    tick(PW + 2);
    fault_n = 1'b1; tick(PW + 4);
    chk(pulses - p0, 1, "R7 one pulse, none on rise");
    err_en_n = 1'b1; tick(1);
    fault_n = 1'b0; tick(PW + 4);
    chk(pulses - p0, 1, "R7 disabled fault ignored");

    // R8: enable while fault already low
    err_en_n = 1'b0;
    tick(1);
    chk(oe, 1, "R8 enable with fault low");
    tick(PW + 2);
    chk(pulses - p0, 2, "R8 pulse count");
    fault_n = 1'b1; err_en_n = 1'b1; tick(4);

    // R9: acknowledge rising edge
    p0 = pulses;
    ack_en = 1'b1;
    ack_n = 1'b0; tick(PW + 4);
    chk(pulses - p0, 0, "R9 falling ack ignored");
    ack_n = 1'b1; tick(PW + 4);
    chk(pulses - p0, 1, "R9 rising ack pulse");
    ack_en = 1'b0;
    ack_n = 1'b0; tick(3); ack_n = 1'b1; tick(PW + 4);
    chk(pulses - p0, 1, "R9 disabled ack ignored");
    chk(bad_val, 0, "R10 value low across run");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule